// File: doc/BRIEF.md
# External Trigger Counter Clock Path

This block turns a slow external event stream into count pulses for a 16-bit up-counter that runs on the timer clock. A 2-bit selector picks one of four trigger sources: the peripheral clock, a slow calibrated reference, an optional low-frequency clock, or an external pin. The pin can be ANDed with a mask pin to gate it. The selected level can be inverted so that falling edges count instead of rising ones. It is then sampled into the timer domain by two flops and passed through a programmable stability filter. An edge detector follows, then a prescaler that passes one edge in 1, 2, 4 or 8.

The counter advances on a prescaler hit only when the external-clock mode and the counter enable are both on. It wraps from all ones to zero and raises a one-cycle overflow flag when it does. The sources are plain inputs. They are sampled and not used as clocks, so the edge rate must stay at or below half the timer clock.

Top module: `ext_trig_clkpath`

## Requirements
- R1: `src_sel` picks the trigger: 0 = `pclk_in`, 1 = `ref_slow_in`, 2 = `lf_clk_in`, 3 = external pin. Activity on an unselected source changes nothing.
- R2: With `src_sel` = 3 and `mask_en` = 1, the pin is ANDed with `pin_mask_in`, so a low mask blocks every pin edge. With `mask_en` = 0, the pin is used directly.
- R3: `pol_inv` = 0 counts rising edges of the selected source. `pol_inv` = 1 counts falling edges, and rising edges then do not count.
- R4: `filt_len` = 0 passes every edge. A value N > 0 accepts a new level only after N consecutive timer-clock samples of that level, so pulses shorter than N cycles are dropped.
- R5: `psc_sel` 0, 1, 2, 3 divides the qualifying edge rate by 1, 2, 4, 8 respectively.
- R6: `count` changes only when both `mode2_en` and `cnt_en` were 1 in the preceding cycle.
- R7: With `filt_len` = 0 and divide by 1, a trigger level change made between clock edges shows up in `count` after the fourth following rising clock edge, and not earlier. `count` never changes on two consecutive cycles.
- R8: `count` steps by exactly one. From 0xFFFF it wraps to 0x0000, and `ovf` is 1 for exactly the one cycle in which the wrapped zero is first visible.
- R9: `rst` (synchronous, active high) clears the counter, `ovf`, the prescaler and the filter state. The prescaler is also cleared while `mode2_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Trigger source select |
| pclk_in | input | 1 | Peripheral clock as a sampled signal |
| ref_slow_in | input | 1 | Slow calibrated reference |
| lf_clk_in | input | 1 | Optional low-frequency clock |
| pin_in | input | 1 | External trigger pin |
| pin_mask_in | input | 1 | Gate pin for the external trigger |
| mask_en | input | 1 | Enables gating of the pin by the mask pin |
| pol_inv | input | 1 | 1 selects falling-edge counting |
| filt_len | input | 4 | Required stable samples before a level change is accepted |
| psc_sel | input | 2 | Edge prescaler select |
| mode2_en | input | 1 | External-clock mode enable |
| cnt_en | input | 1 | Counter enable |
| count | output | 16 | Counter value |
| ovf | output | 1 | One-cycle wrap flag |

## Verification
The assertions check on every cycle that the counter only ever steps by one and only after both enables were set. They also check that two consecutive cycles never both bring a change, that an overflow flag always follows a wrap from all ones and lasts one cycle, and that the prescaler is empty whenever the mode is off. Source selection, mask gating, polarity, filter rejection of short pulses, the division ratios and the exact four-edge latency depend on what the input stream looks like. Only the bench's scenarios show these, by counting the result of known pulse trains.

// File: rtl/ext_trig_clkpath.sv
module ext_trig_clkpath #(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        src_sel,
  input  logic              pclk_in,
  input  logic              ref_slow_in,
  input  logic              lf_clk_in,
  input  logic              pin_in,
  input  logic              pin_mask_in,
  input  logic              mask_en,
  input  logic              pol_inv,
  input  logic [FILT_W-1:0] filt_len,
  input  logic [1:0]        psc_sel,
  input  logic              mode2_en,
  input  logic              cnt_en,
  output logic [CNT_W-1:0]  count,
  output logic              ovf
);

  localparam int PSC_W = 3;

  logic              pin_gated, raw, trig;
  logic              s1, s2, lvl, lvl_d, rise, psc_hit, inc;
  logic [FILT_W-1:0] stab;
  logic [PSC_W-1:0]  psc_cnt, psc_mask;

  assign pin_gated = mask_en ? (pin_in & pin_mask_in) : pin_in;

  always_comb begin
    case (src_sel)
      2'd0:    raw = pclk_in;
      2'd1:    raw = ref_slow_in;
      2'd2:    raw = lf_clk_in;
      default: raw = pin_gated;
    endcase
  end

  assign trig = raw ^ pol_inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= trig;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl  <= 1'b0;
      stab <= '0;
    end else if (s2 == lvl) begin
      stab <= '0;
    end else if ({1'b0, stab} + 1'b1 >= {1'b0, filt_len}) begin
      lvl  <= s2;
      stab <= '0;
    end else begin
      stab <= stab + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;

  always_comb begin
    case (psc_sel)
      2'd0:    psc_mask = 3'b000;
      2'd1:    psc_mask = 3'b001;
      2'd2:    psc_mask = 3'b011;
      default: psc_mask = 3'b111;
    endcase
  end

  assign psc_hit = rise && ((psc_cnt & psc_mask) == psc_mask);

  always_ff @(posedge clk) begin
    if (rst || !mode2_en) psc_cnt <= '0;
    else if (rise)        psc_cnt <= psc_hit ? '0 : psc_cnt + 1'b1;
  end

  assign inc = psc_hit & mode2_en & cnt_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= inc && (&count);
      if (inc) count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/ext_trig_clkpath_chk.sv
module ext_trig_clkpath_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mode2_en,
  input logic             cnt_en,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic [2:0]       psc_cnt
);

  a_r6_enables: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && count != $past(count)) |-> $past(mode2_en && cnt_en));

  a_r7_spacing: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && count != $past(count)) |=> (count == $past(count)));

  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));

  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ovf) |-> (count == '0 && $past(count) == '1));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ovf |=> !ovf);

  a_r9_psc_clear: assert property (@(posedge clk) disable iff (rst)
    !mode2_en |=> (psc_cnt == '0));

endmodule

bind ext_trig_clkpath ext_trig_clkpath_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode2_en(mode2_en), .cnt_en(cnt_en),
  .count(count), .ovf(ovf), .psc_cnt(psc_cnt)
);

// File: tb/ext_trig_clkpath_bench.sv
`timescale 1ns/1ps
module ext_trig_clkpath_bench;

  typedef struct packed {
    logic [1:0]  sel;
    logic [1:0]  pulse;
    logic        men;
    logic        mpin;
    logic        pol;
    logic [3:0]  filt;
    logic [1:0]  psc;
    logic        m2;
    logic        ce;
    logic [7:0]  n;
    logic [3:0]  hold;
    logic [15:0] want;
  } row_t;

  localparam row_t ROWS [0:16] = '{
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 8'd5,  4'd3, 16'd5},
    '{2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 8'd4,  4'd3, 16'd4},
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 8'd3,  4'd3, 16'd3},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 8'd6,  4'd3, 16'd6},
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 8'd4,  4'd3, 16'd0},
    '{2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 8'd4,  4'd3, 16'd0},
    '{2'd3, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0, 2'd0, 1'b1, 1'b1, 8'd5,  4'd3, 16'd5},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b1, 4'd0, 2'd0, 1'b1, 1'b1, 8'd5,  4'd3, 16'd5},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 2'd1, 1'b1, 1'b1, 8'd8,  4'd3, 16'd4},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 2'd2, 1'b1, 1'b1, 8'd8,  4'd3, 16'd2},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 2'd3, 1'b1, 1'b1, 8'd16, 4'd3, 16'd2},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 2'd1, 1'b1, 1'b1, 8'd7,  4'd3, 16'd3},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b0, 1'b1, 8'd4,  4'd3, 16'd0},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 1'b0, 8'd4,  4'd3, 16'd0},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd3, 2'd0, 1'b1, 1'b1, 8'd6,  4'd4, 16'd6},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd5, 2'd0, 1'b1, 1'b1, 8'd4,  4'd4, 16'd0},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 4'd4, 2'd0, 1'b1, 1'b1, 8'd3,  4'd4, 16'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_sel = 2'd0;
  logic [3:0]  srcv = 4'd0;
  logic        pin_mask_in = 1'b0;
  logic        mask_en = 1'b0;
  logic        pol_inv = 1'b0;
  logic [3:0]  filt_len = 4'd0;
  logic [1:0]  psc_sel = 2'd0;
  logic        mode2_en = 1'b0;
  logic        cnt_en = 1'b0;
  logic [15:0] count;
  logic        ovf;
  int          total = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  ext_trig_clkpath u_ext_trig_clkpath (
    .clk(clk), .rst(rst), .src_sel(src_sel),
    .pclk_in(srcv[0]), .ref_slow_in(srcv[1]), .lf_clk_in(srcv[2]), .pin_in(srcv[3]),
    .pin_mask_in(pin_mask_in), .mask_en(mask_en), .pol_inv(pol_inv),
    .filt_len(filt_len), .psc_sel(psc_sel), .mode2_en(mode2_en), .cnt_en(cnt_en),
    .count(count), .ovf(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] want);
    total++;
    if (act !== want) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, want);
    end
  endtask

  function automatic string tag_of(input int i);
    if (i <= 4)  return "R1 source select";
    if (i <= 6)  return "R2 mask gate";
    if (i == 7)  return "R3 polarity";
    if (i <= 11) return "R5 prescaler";
    if (i <= 13) return "R6 enables";
    return "R4 filter";
  endfunction

  task automatic setup(input row_t r);
    @(negedge clk);
    src_sel = r.sel; mask_en = r.men; pin_mask_in = r.mpin; pol_inv = r.pol;
    filt_len = r.filt; psc_sel = r.psc; mode2_en = r.m2; cnt_en = r.ce;
    srcv = {4{r.pol}};
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulses(input logic [1:0] idx, input logic idle, input int n, input int hold);
    for (int p = 0; p < n; p++) begin
      srcv[idx] = ~idle;
      repeat (hold) @(negedge clk);
      srcv[idx] = idle;
      repeat (hold) @(negedge clk);
    end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    row_t d;
    repeat (3) @(negedge clk);
    chk("R9 reset count", 32'(count), 32'd0);
    chk("R9 reset ovf", 32'(ovf), 32'd0);

    for (int i = 0; i < 17; i++) begin
      setup(ROWS[i]);
      pulses(ROWS[i].pulse, ROWS[i].pol, int'(ROWS[i].n), int'(ROWS[i].hold));
      chk($sformatf("%s row %0d", tag_of(i), i), 32'(count), 32'(ROWS[i].want));
    end

    d = ROWS[3];
    setup(d);
    srcv[3] = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R7 no change before fourth edge", 32'(count), 32'd0);
    @(posedge clk);
    #1 chk("R7 change at fourth edge", 32'(count), 32'd1);

    setup(d);
    srcv[3] = 1'b1; repeat (8) @(negedge clk);
    chk("R3 rising counted", 32'(count), 32'd1);
    srcv[3] = 1'b0; repeat (8) @(negedge clk);
    chk("R3 falling ignored", 32'(count), 32'd1);
    d.pol = 1'b1;
    setup(d);
    srcv[3] = 1'b0; repeat (8) @(negedge clk);
    chk("R3 falling counted", 32'(count), 32'd1);
    srcv[3] = 1'b1; repeat (8) @(negedge clk);
    chk("R3 rising ignored", 32'(count), 32'd1);

    d = ROWS[8];
    setup(d);
    pulses(2'd3, 1'b0, 1, 3);
    chk("R5 half edge pending", 32'(count), 32'd0);
    mode2_en = 1'b0; @(negedge clk); mode2_en = 1'b1; @(negedge clk);
    pulses(2'd3, 1'b0, 1, 3);
    chk("R9 prescaler cleared by mode off", 32'(count), 32'd0);
    pulses(2'd3, 1'b0, 1, 3);
    chk("R9 prescaler counts again", 32'(count), 32'd1);
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk("R9 reset clears count", 32'(count), 32'd0);

    d = ROWS[0];
    setup(d);
    for (int k = 0; k < 140000 && count != 16'hFFFF; k++) begin
      srcv[0] = ~srcv[0];
      @(negedge clk);
    end
    chk("R8 reached all ones", 32'(count), 32'hFFFF);
    chk("R8 no flag before wrap", 32'(ovf), 32'd0);
    for (int k = 0; k < 10 && count == 16'hFFFF; k++) begin
      srcv[0] = ~srcv[0];
      @(negedge clk);
    end
    chk("R8 wraps to zero", 32'(count), 32'd0);
    chk("R8 flag on wrap", 32'(ovf), 32'd1);
    srcv[0] = ~srcv[0];
    @(negedge clk);
    chk("R8 flag lasts one cycle", 32'(ovf), 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule